// File: doc/BRIEF.md
# Multithreaded Windowed Register File

This block holds the integer registers of many hardware threads that share one in-order pipeline. Each thread runs a core with overlapping register windows, and all the threads live in one synchronous RAM. The RAM is split into equal slices whose size is a power of two. The thread id supplies the upper address bits. Inside a slice, the thread's current window pointer and the 5-bit architectural register number select an entry, so that registers shared between neighbouring windows land on the same physical word.

There are two read ports, which share one thread id and one window pointer, as an issue stage would use them. There is one write port, which has its own thread id and window pointer, as a writeback stage would use it. The entries of a slice that no register uses hold a per-thread trap base word. Read port A and the write port reach it through a select flag. Reads take one cycle. Nothing is forwarded from the write port to the read ports. Register 0 is hard-wired to zero.

Top module: `mt_winreg_file`

## Requirements
- R1: While reset is low at a clock edge, both read data outputs are zero after that edge.
- R2: A read address presented before a clock edge has its data on the output after that edge, and the data stays there until the next edge.
- R3: Registers 0 to 7 are global to a thread. A value written under one window pointer reads back the same under every window pointer of that thread.
- R4: Registers 16 to 23 (locals) and 24 to 31 (ins) are private to each of the three windows. A write under one window pointer leaves the same register number under the other pointers unchanged.
- R5: Register 8+k (outs) under window pointer w is the same storage as register 24+k (ins) under window pointer (w+2) mod 3, for k from 0 to 7. The window pointer must be 0, 1 or 2.
- R6: Reading register 0 always returns zero, and a write to register 0 has no effect.
- R7: Threads are isolated. A write under one thread id leaves every register of every other thread unchanged.
- R8: Each thread has one trap base word. It is written when the write port's trap select is high and read on port A when the read trap select is high. It is separate from all of that thread's registers.
- R9: There is no bypass. A read and a write to the same entry in the same cycle return the old value, and a read in the following cycle returns the new value.
- R10: Both read ports return their own registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_tid | input | 6 | Thread id for both read ports |
| rd_cwp | input | 2 | Window pointer for both read ports |
| ra_reg | input | 5 | Register number, read port A |
| ra_tbr | input | 1 | Port A reads the trap base word instead of a register |
| rb_reg | input | 5 | Register number, read port B |
| ra_data | output | 32 | Read data, port A (one-cycle latency) |
| rb_data | output | 32 | Read data, port B (one-cycle latency) |
| wr_en | input | 1 | Write enable |
| wr_tid | input | 6 | Thread id for the write |
| wr_cwp | input | 2 | Window pointer for the write |
| wr_reg | input | 5 | Register number for the write |
| wr_tbr | input | 1 | Write the trap base word instead of a register |
| wr_data | input | 32 | Write data |

## Verification
A read and a write to the same physical entry can fall in the same cycle. The entry can be the same register name, or two aliased names from different windows. The bench provokes this by driving both ports to one entry before a single edge. It expects the old contents at the output after that edge and the new contents one read later. A second collision comes from window aliasing. An out register written under one window pointer must appear as an in register under the previous window. A behavioural model keyed by owner window checks this across random thread ids, window pointers and register numbers.

// File: rtl/mt_winreg_pkg.sv
// Package: shared types for the windowed register file.
// Assumes the 5-bit register number splits into a 2-bit class and a 3-bit slot.
package mt_winreg_pkg;
    typedef enum logic [1:0] {
        CLS_GLOBAL = 2'd0,  // r0..r7
        CLS_OUT    = 2'd1,  // r8..r15
        CLS_LOCAL  = 2'd2,  // r16..r23
        CLS_IN     = 2'd3   // r24..r31
    } reg_class_e;

    localparam int BANK_REGS = 8;  // registers per class, fixed by the encoding
endpackage

// File: rtl/mt_winreg_addr_map.sv
// Module: mt_winreg_addr_map
// Turns (thread, window pointer, register number, trap select) into a flat RAM address.
// Slice layout: globals at entries 0..GLOBALS-1. Each window then owns WIN_REGS entries,
// locals first and ins after them. Outs resolve to the ins of the previous window.
// The trap base word sits just above the last window.
// Assumes cwp < NWIN and that the slice is large enough (checked at elaboration).
module mt_winreg_addr_map
    import mt_winreg_pkg::*;
#(
    parameter int TID_W    = 6,
    parameter int NWIN     = 3,
    parameter int GLOBALS  = 8,
    parameter int WIN_REGS = 16,
    parameter int IDX_W    = 6,
    parameter int CWP_W    = 2
) (
    input  logic [TID_W-1:0]       tid,
    input  logic [CWP_W-1:0]       cwp,
    input  logic [4:0]             rnum,
    input  logic                   tbr,
    output logic [TID_W+IDX_W-1:0] addr
);
    localparam int TBR_IDX = GLOBALS + NWIN * WIN_REGS;

    if (TBR_IDX >= (1 << IDX_W)) begin : g_bad_slice
        initial $error("slice too small for registers plus trap base word");
    end

    reg_class_e       cls;
    logic [2:0]       slot;
    logic [CWP_W-1:0] owner;
    int unsigned      idx;

    // Split the register number and find which window owns the storage.
    always_comb begin
        cls  = reg_class_e'(rnum[4:3]);
        slot = rnum[2:0];
        if (cls == CLS_OUT)
            owner = (cwp == '0) ? CWP_W'(NWIN - 1) : cwp - CWP_W'(1);
        else
            owner = cwp;
    end

    // Compute the slice index, then append the thread id as the upper bits.
    always_comb begin
        if (tbr)
            idx = TBR_IDX;
        else if (cls == CLS_GLOBAL)
            idx = 32'(slot);
        else
            idx = GLOBALS + 32'(owner) * WIN_REGS
                + ((cls == CLS_LOCAL) ? 0 : BANK_REGS) + 32'(slot);
        addr = {tid, idx[IDX_W-1:0]};
    end
endmodule

// File: rtl/mt_winreg_store.sv
// Module: mt_winreg_store
// Storage array with two registered read ports and one write port.
// A read and a write to one address in the same cycle return the old word (no bypass).
// Assumes the contents are not reset. Callers write an entry before they read it.
module mt_winreg_store #(
    parameter int DW = 32,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] ra_q,
    output logic [DW-1:0] rb_q,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    // Write the array and capture both read words, old contents first.
    always_ff @(posedge clk) begin
        if (we)
            mem[wa] <= wd;
        ra_q <= mem[ra_addr];
        rb_q <= mem[rb_addr];
    end
endmodule

// File: rtl/mt_winreg_file.sv
// Module: mt_winreg_file (top)
// Per-thread windowed integer register file for a fine-grained multithreaded pipeline.
// Three address mappers (read A, read B, write) drive one shared storage array.
// Reads of register 0 are forced to zero one cycle later, and writes to it are dropped.
// Assumes window pointers stay below NWIN. Synchronous active-low reset clears only the outputs.
module mt_winreg_file #(
    parameter int THREADS  = 64,
    parameter int DW       = 32,
    parameter int NWIN     = 3,
    parameter int GLOBALS  = 8,
    parameter int WIN_REGS = 16,
    parameter int SLICE    = 64,
    localparam int TID_W   = $clog2(THREADS),
    localparam int CWP_W   = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TID_W-1:0] rd_tid,
    input  logic [CWP_W-1:0] rd_cwp,
    input  logic [4:0]       ra_reg,
    input  logic             ra_tbr,
    input  logic [4:0]       rb_reg,
    output logic [DW-1:0]    ra_data,
    output logic [DW-1:0]    rb_data,
    input  logic             wr_en,
    input  logic [TID_W-1:0] wr_tid,
    input  logic [CWP_W-1:0] wr_cwp,
    input  logic [4:0]       wr_reg,
    input  logic             wr_tbr,
    input  logic [DW-1:0]    wr_data
);
    localparam int IDX_W = $clog2(SLICE);
    localparam int AW    = TID_W + IDX_W;
    localparam int NPORT = 3;  // 0: read A, 1: read B, 2: write

    logic [TID_W-1:0] p_tid  [NPORT];
    logic [CWP_W-1:0] p_cwp  [NPORT];
    logic [4:0]       p_reg  [NPORT];
    logic             p_tbr  [NPORT];
    logic [AW-1:0]    p_addr [NPORT];

    // Gather the per-port request fields so one generate loop can map them.
    always_comb begin
        p_tid[0] = rd_tid; p_cwp[0] = rd_cwp; p_reg[0] = ra_reg; p_tbr[0] = ra_tbr;
        p_tid[1] = rd_tid; p_cwp[1] = rd_cwp; p_reg[1] = rb_reg; p_tbr[1] = 1'b0;
        p_tid[2] = wr_tid; p_cwp[2] = wr_cwp; p_reg[2] = wr_reg; p_tbr[2] = wr_tbr;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        mt_winreg_addr_map #(
            .TID_W(TID_W), .NWIN(NWIN), .GLOBALS(GLOBALS),
            .WIN_REGS(WIN_REGS), .IDX_W(IDX_W), .CWP_W(CWP_W)
        ) u_map (
            .tid(p_tid[p]), .cwp(p_cwp[p]), .rnum(p_reg[p]),
            .tbr(p_tbr[p]), .addr(p_addr[p])
        );
    end

    logic          mem_we;
    logic [DW-1:0] ra_q, rb_q;
    logic          ra_zero_q, rb_zero_q;

    // Drop writes that name register 0. The trap base word is always writable.
    always_comb mem_we = wr_en && (wr_tbr || wr_reg != 5'd0);

    mt_winreg_store #(.DW(DW), .AW(AW)) u_store (
        .clk(clk), .ra_addr(p_addr[0]), .rb_addr(p_addr[1]),
        .ra_q(ra_q), .rb_q(rb_q),
        .we(mem_we), .wa(p_addr[2]), .wd(wr_data)
    );

    // Remember, alongside the RAM read, whether each port asked for register 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_zero_q <= 1'b1;
            rb_zero_q <= 1'b1;
        end else begin
            ra_zero_q <= (ra_reg == 5'd0) && !ra_tbr;
            rb_zero_q <= (rb_reg == 5'd0);
        end
    end

    // Present RAM words, or zero for register 0 and for the cycle after reset.
    always_comb begin
        ra_data = ra_zero_q ? '0 : ra_q;
        rb_data = rb_zero_q ? '0 : rb_q;
    end

    // R1: reset leaves both outputs at zero.
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (ra_data == '0 && rb_data == '0));

    // R6: a register-0 request on a port yields zero on the next cycle.
    a_r6_zero_read_a: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_reg == 5'd0 && !ra_tbr) |=> ra_data == '0);
    a_r6_zero_read_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_reg == 5'd0) |=> rb_data == '0);

    // R6: no write reaching the array ever targets a thread's register-0 entry.
    a_r6_no_r0_store: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> p_addr[2][IDX_W-1:0] != '0);

    // R5: window pointers stay inside the implemented windows.
    a_r5_cwp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd_cwp) < NWIN) && (!wr_en || 32'(wr_cwp) < NWIN));
endmodule

// File: tb/sim_mt_winreg_file.sv
module sim_mt_winreg_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  rd_tid = '0, wr_tid = '0;
    logic [1:0]  rd_cwp = '0, wr_cwp = '0;
    logic [4:0]  ra_reg = '0, rb_reg = '0, wr_reg = '0;
    logic        ra_tbr = 1'b0, wr_tbr = 1'b0, wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ra_data, rb_data;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;  // 100 MHz

    mt_winreg_file u0 (
        .clk(clk), .rst_n(rst_n), .rd_tid(rd_tid), .rd_cwp(rd_cwp),
        .ra_reg(ra_reg), .ra_tbr(ra_tbr), .rb_reg(rb_reg),
        .ra_data(ra_data), .rb_data(rb_data),
        .wr_en(wr_en), .wr_tid(wr_tid), .wr_cwp(wr_cwp), .wr_reg(wr_reg),
        .wr_tbr(wr_tbr), .wr_data(wr_data)
    );

    // Vector: {is_write, tbr, tid[6], cwp[2], reg[5], data[32], req[4]}
    localparam int NV = 14;
    localparam logic [50:0] VEC [NV] = '{
        {1'b1, 1'b0, 6'd1, 2'd0, 5'd1,  32'h1111_1111, 4'd3},
        {1'b1, 1'b0, 6'd1, 2'd1, 5'd17, 32'hA000_0017, 4'd4},
        {1'b1, 1'b0, 6'd1, 2'd2, 5'd17, 32'hB000_0017, 4'd4},
        {1'b1, 1'b0, 6'd1, 2'd1, 5'd9,  32'hC000_0009, 4'd5},
        {1'b1, 1'b0, 6'd2, 2'd1, 5'd17, 32'hD000_0017, 4'd7},
        {1'b1, 1'b1, 6'd1, 2'd0, 5'd0,  32'h0000_4000, 4'd8},
        {1'b1, 1'b0, 6'd1, 2'd0, 5'd0,  32'hFFFF_FFFF, 4'd6},
        {1'b0, 1'b0, 6'd1, 2'd2, 5'd1,  32'h1111_1111, 4'd3},  // R3 global seen from window 2
        {1'b0, 1'b0, 6'd1, 2'd1, 5'd17, 32'hA000_0017, 4'd4},  // R4 local of window 1
        {1'b0, 1'b0, 6'd1, 2'd2, 5'd17, 32'hB000_0017, 4'd4},  // R4 local of window 2
        {1'b0, 1'b0, 6'd1, 2'd0, 5'd25, 32'hC000_0009, 4'd5},  // R5 out r9 of w1 = in r25 of w0
        {1'b0, 1'b0, 6'd2, 2'd1, 5'd17, 32'hD000_0017, 4'd7},  // R7 thread 2 untouched
        {1'b0, 1'b1, 6'd1, 2'd0, 5'd0,  32'h0000_4000, 4'd8},  // R8 trap base word
        {1'b0, 1'b0, 6'd1, 2'd0, 5'd0,  32'h0000_0000, 4'd6}   // R6 r0 still zero
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] t, input logic [1:0] c, input logic [4:0] r,
                      input logic tb, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_tid = t; wr_cwp = c; wr_reg = r; wr_tbr = tb; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_tbr = 1'b0;
    endtask

    // Issue a read and sample one cycle later, away from the edge.
    task automatic rd(input logic [5:0] t, input logic [1:0] c, input logic [4:0] ra,
                      input logic tb, input logic [4:0] rb);
        @(negedge clk);
        rd_tid = t; rd_cwp = c; ra_reg = ra; ra_tbr = tb; rb_reg = rb;
        @(negedge clk);
    endtask

    // Behavioural model for the random phase: threads 0..3, keyed by owner window.
    logic [31:0] mdl [4][64];
    bit          mv  [4][64];

    function automatic int key(input int c, input int r);
        if (r < 8)  return r;
        if (r < 16) return 8 + ((c + 2) % 3) * 16 + 8 + (r - 8);  // outs belong to previous window's ins
        if (r < 24) return 8 + c * 16 + (r - 16);
        return 8 + c * 16 + 8 + (r - 24);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        // R1: reset state of the outputs
        rd_tid = 6'd1; ra_reg = 5'd5; rb_reg = 5'd6;
        repeat (3) @(negedge clk);
        chk("R1 ra_data after reset", ra_data, 32'h0);
        chk("R1 rb_data after reset", rb_data, 32'h0);
        rst_n = 1'b1;

        // Table walk: writes first, then read-backs carrying their requirement.
        for (int i = 0; i < NV; i++) begin
            logic [50:0] v;
            v = VEC[i];
            if (v[50])
                wr(v[48:43], v[42:41], v[40:36], v[49], v[35:4]);
            else begin
                rd(v[48:43], v[42:41], v[40:36], v[49], 5'd0);
                chk($sformatf("R%0d vector %0d", v[3:0], i), ra_data, v[35:4]);
            end
        end

        // R4: ins are private per window (write w0 r28, w1 r28 stays distinct)
        wr(6'd5, 2'd0, 5'd28, 1'b0, 32'h0505_0028);
        wr(6'd5, 2'd1, 5'd28, 1'b0, 32'h1515_0028);
        rd(6'd5, 2'd0, 5'd28, 1'b0, 5'd0);
        chk("R4 in r28 window 0", ra_data, 32'h0505_0028);

        // R8: trap base word separate from every register of the thread
        wr(6'd5, 2'd0, 5'd0, 1'b1, 32'hBEEF_0000);
        rd(6'd5, 2'd0, 5'd28, 1'b0, 5'd28);
        chk("R8 r28 unaffected by trap base write", rb_data, 32'h0505_0028);

        // R10: both ports in one cycle, different registers
        rd(6'd1, 2'd2, 5'd1, 1'b0, 5'd17);
        chk("R10 port A global", ra_data, 32'h1111_1111);
        chk("R10 port B local", rb_data, 32'hB000_0017);

        // R2: data holds until the next edge after new address is presented
        rd(6'd1, 2'd1, 5'd17, 1'b0, 5'd0);
        ra_reg = 5'd1;
        #4;
        chk("R2 output held before next edge", ra_data, 32'hA000_0017);
        @(negedge clk);
        chk("R2 new address after one edge", ra_data, 32'h1111_1111);

        // R9: same-cycle read and write via aliased names (out r10 w2 = in r26 w1)
        wr(6'd7, 2'd1, 5'd26, 1'b0, 32'h0000_0A1D);
        @(negedge clk);
        wr_en = 1'b1; wr_tid = 6'd7; wr_cwp = 2'd2; wr_reg = 5'd10; wr_data = 32'h0000_0E3F;
        rd_tid = 6'd7; rd_cwp = 2'd1; ra_reg = 5'd26; ra_tbr = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 collision returns old word", ra_data, 32'h0000_0A1D);
        @(negedge clk);
        chk("R9 next read returns new word", ra_data, 32'h0000_0E3F);

        // R3 R4 R5 R7: random traffic against the behavioural model
        for (int t = 0; t < 4; t++)
            for (int e = 0; e < 64; e++) mv[t][e] = 0;
        void'($urandom(32'd2024));
        for (int n = 0; n < 600; n++) begin
            int t, c, r, r2;
            t = $urandom % 4; c = $urandom % 3; r = $urandom % 32; r2 = $urandom % 32;
            if ($urandom % 2) begin
                logic [31:0] d;
                d = $urandom;
                wr(6'(8 + t), 2'(c), 5'(r), 1'b0, d);
                if (r != 0) begin
                    mdl[t][key(c, r)] = d;
                    mv[t][key(c, r)] = 1;
                end
            end else begin
                rd(6'(8 + t), 2'(c), 5'(r), 1'b0, 5'(r2));
                if (r == 0)
                    chk("R6 random r0 read", ra_data, 32'h0);
                else if (mv[t][key(c, r)])
                    chk("R5 R7 random port A vs model", ra_data, mdl[t][key(c, r)]);
                if (r2 != 0 && mv[t][key(c, r2)])
                    chk("R3 R4 random port B vs model", rb_data, mdl[t][key(c, r2)]);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule